// File: doc/BRIEF.md
# Stereo DC Offset Remover with Estimate Hold

This block sits on the decimated sample stream of a stereo audio converter and removes the DC component of each channel. Every sample carries a channel tag. For the channel it names, the block keeps a running offset estimate in a leaky integrator. It subtracts that estimate from the sample and sends the result out one clock later, with the same channel tag.

A hold control stops the integrator from learning but still subtracts the stored estimate. This supports a one-time system calibration. First the signal source is removed and the stage is left tracking until the estimate settles, which takes about a second of audio at the nominal rate. Then the hold is raised, and from that point the measured offset of the whole path keeps being removed without the filter following the signal.

The hold input is sampled together with each accepted sample. An estimate therefore changes only at a sample boundary and is never half updated. The subtraction clamps to the signed sample range, so it cannot wrap.

Top module: `dc_trim_hp`

## Requirements
- R1: For each accepted sample x on channel c, `out_data` equals x minus the estimate of channel c as it stood before this sample, clamped to the signed DW-bit range.
- R2: An accepted sample with `hold` low updates its channel's accumulator A to A + x − (A >>> K) (arithmetic shift), and the estimate is A >>> K. A constant input therefore drives the output to within ±1 of zero once the estimate has settled.
- R3: The subtraction saturates. A positive difference beyond the range gives 2^(DW-1)−1, and a negative one gives −2^(DW-1).
- R4: Channels keep independent estimates, selected by `in_ch` (0 = left, 1 = right). A sample on one channel leaves every other channel's estimate unchanged.
- R5: An accepted sample with `hold` high leaves its channel's estimate unchanged, and the held estimate is still subtracted from it.
- R6: `out_valid` is `in_valid` delayed by exactly one clock, and `out_ch` repeats the tag of the sample it belongs to.
- R7: In a cycle with `in_valid` low, no estimate changes, and `out_valid` is low in the following cycle.
- R8: While `rst_n` is low at a clock edge, every estimate is cleared to zero and `out_valid` and `out_data` are cleared to zero. After reset the stage is in tracking mode unless `hold` is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | CW | Channel tag of the input sample (0 left, 1 right) |
| in_data | input | DW | Signed input sample |
| hold | input | 1 | 1 = freeze the offset estimate of the sampled channel |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | CW | Channel tag of the output sample |
| out_data | output | DW | Signed, offset-corrected sample |

## Verification
The hardest situation to reach is the clamp. It needs an estimate pinned near one end of the range while a sample arrives from the other end, and the estimate only gets there after thousands of samples of full-scale input. The bench trains one channel at negative full scale and the other at positive full scale. It then raises the hold and sends the opposite extreme on each channel, which checks the clamp and the preserved estimate together. A reference model of the integrator, built from the requirements, predicts every output sample throughout the run.

// File: rtl/dc_trim_pkg.sv
// dc_trim_pkg
// Shared defaults for the DC offset remover.
// Assumes: consumers derive every width from these values or from their own parameters.
package dc_trim_pkg;
    localparam int DEF_DW  = 16;   // sample width
    localparam int DEF_K   = 12;   // integrator shift
    localparam int DEF_NCH = 2;    // number of channels
endpackage

// File: rtl/dc_est_chan.sv
// dc_est_chan
// Leaky-integrator DC estimate for a single channel.
// Updates only when 'upd' is high: A <= A + x - (A >>> K); est = A >>> K.
// Assumes: x is a signed DW-bit sample. A fits in DW+K bits because the
// integrator's fixed point always lies within the input range.
module dc_est_chan #(
    parameter int DW = 16,
    parameter int K  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] est
);
    localparam int AW = DW + K;

    logic signed [AW-1:0] acc_q;
    logic signed [AW:0]   sum;

    // Estimate is the integer part of the accumulator.
    assign est = acc_q[AW-1:K];

    // Next accumulator value, computed one bit wider than the accumulator.
    always_comb begin
        sum = {acc_q[AW-1], acc_q}
            + {{(K+1){x[DW-1]}}, x}
            - {{(K+1){est[DW-1]}}, est};
    end

    // Accumulator register: cleared in reset, advanced on update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (upd)
            acc_q <= sum[AW-1:0];
    end
endmodule

// File: rtl/dc_sat_sub.sv
// dc_sat_sub
// Combinational signed subtraction y = a - b, clamped to the DW-bit range.
// Assumes: a and b are signed DW-bit values.
module dc_sat_sub #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] y
);
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0] diff;

    // Full-precision difference, then clamp when the top two bits disagree.
    always_comb begin
        diff = {a[DW-1], a} - {b[DW-1], b};
        if (diff[DW] != diff[DW-1])
            y = diff[DW] ? MINV : MAXV;
        else
            y = diff[DW-1:0];
    end
endmodule

// File: rtl/dc_trim_hp.sv
// dc_trim_hp
// Streaming stereo DC offset remover with a hold on the estimate.
// Each accepted sample is corrected by the estimate of its channel as it stood
// before that sample. The estimate then learns from the sample unless 'hold' is high.
// The output is registered, so it arrives one clock after the input.
// Assumes: in_ch < NCH; synchronous active-low reset.
module dc_trim_hp #(
    parameter int DW  = dc_trim_pkg::DEF_DW,
    parameter int K   = dc_trim_pkg::DEF_K,
    parameter int NCH = dc_trim_pkg::DEF_NCH,
    parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CW-1:0]        in_ch,
    input  logic signed [DW-1:0] in_data,
    input  logic                 hold,
    output logic                 out_valid,
    output logic [CW-1:0]        out_ch,
    output logic signed [DW-1:0] out_data
);
    logic [NCH-1:0][DW-1:0] est_all;
    logic signed [DW-1:0]   est_sel;
    logic signed [DW-1:0]   corr;

    // One estimator per channel, each enabled by its own tag match.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic upd_c;
        assign upd_c = in_valid && !hold && (in_ch == CW'(c));
        dc_est_chan #(.DW(DW), .K(K)) est_i (
            .clk  (clk),
            .rst_n(rst_n),
            .upd  (upd_c),
            .x    (in_data),
            .est  (est_all[c])
        );
    end

    // Pick the estimate of the channel being processed.
    assign est_sel = est_all[in_ch];

    dc_sat_sub #(.DW(DW)) sub_i (
        .a(in_data),
        .b(est_sel),
        .y(corr)
    );

    // Output register: corrected sample, its tag and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_ch   <= in_ch;
                out_data <= corr;
            end
        end
    end
endmodule

// File: rtl/dc_trim_hp_chk.sv
// dc_trim_hp_chk
// Property checker for dc_trim_hp, attached with the bind at the end of this file.
// Assumes: est_all is the top's per-channel estimate vector.
module dc_trim_hp_chk #(
    parameter int DW  = 16,
    parameter int NCH = 2,
    parameter int CW  = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [CW-1:0]          in_ch,
    input logic signed [DW-1:0]   in_data,
    input logic                   hold,
    input logic                   out_valid,
    input logic signed [DW-1:0]   out_data,
    input logic [NCH-1:0][DW-1:0] est_all,
    input logic signed [DW-1:0]   est_sel
);
    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    idle_est_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(est_all));

    // R5
    hold_keeps_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hold) |=> $stable(est_all));

    // R3
    no_wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_data[DW-1] && est_sel[DW-1]) |=> !out_data[DW-1]);

    // R3
    no_wrap_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[DW-1] && !est_sel[DW-1] && (est_sel != '0)) |=> out_data[DW-1]);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (est_all == '0) && !out_valid);

    for (genvar c = 0; c < NCH; c++) begin : g_ind
        // R4
        other_chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ch != CW'(c)) |=> $stable(est_all[c]));
    end
endmodule

bind dc_trim_hp dc_trim_hp_chk #(.DW(DW), .NCH(NCH), .CW(CW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ch    (in_ch),
    .in_data  (in_data),
    .hold     (hold),
    .out_valid(out_valid),
    .out_data (out_data),
    .est_all  (est_all),
    .est_sel  (est_sel)
);

// File: tb/dc_trim_hp_tb_top.sv
// Directed bench for dc_trim_hp. A reference integrator, built from the
// requirements, predicts every output sample.
module dc_trim_hp_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  DW = 16;
    localparam int  K  = 8;
    localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (DW-1));

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [0:0]           in_ch = '0;
    logic signed [DW-1:0] in_data = '0;
    logic                 hold = 1'b0;
    logic                 out_valid;
    logic [0:0]           out_ch;
    logic signed [DW-1:0] out_data;

    int tests = 0;
    int fails = 0;
    longint acc_m [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_trim_hp #(.DW(DW), .K(K), .NCH(2), .CW(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
        .in_data(in_data), .hold(hold), .out_valid(out_valid),
        .out_ch(out_ch), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic longint est_m(input int ch);
        return acc_m[ch] >>> K;
    endfunction

    // Send one sample, check the next output against the model, update the model.
    task automatic send(input int ch, input longint x, input bit frz, input string req);
        longint expv;
        in_valid = 1'b1;
        in_ch    = ch[0:0];
        in_data  = x[DW-1:0];
        hold     = frz;
        expv = sat(x - est_m(ch));
        if (!frz) acc_m[ch] = acc_m[ch] + x - est_m(ch);
        @(negedge clk);
        chk(out_valid === 1'b1, "R6 out_valid", longint'(out_valid), 1);
        chk(out_ch === ch[0:0], "R6 out_ch", longint'(out_ch), ch);
        chk(longint'(out_data) == expv, req, longint'(out_data), expv);
    endtask

    task automatic go_idle(input int n);
        in_valid = 1'b0;
        hold     = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R7 idle out_valid", longint'(out_valid), 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        hold = 1'b0;
        acc_m[0] = 0;
        acc_m[1] = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R8: outputs cleared during reset, first sample passes unchanged.
    task automatic t_reset();
        do_reset();
        chk(out_valid === 1'b0, "R8 out_valid", longint'(out_valid), 0);
        chk(out_data === '0, "R8 out_data", longint'(out_data), 0);
        send(0, 1234, 1'b0, "R8 first sample untouched");
        send(1, -777, 1'b0, "R1 right first sample");
        go_idle(1);
    endtask

    // R2: constant input on left settles to zero; R4: right untouched.
    task automatic t_track();
        do_reset();
        for (int i = 0; i < 3000; i++) send(0, 1000, 1'b0, "R2 tracking left");
        chk(out_data >= -1 && out_data <= 1, "R2 settled", longint'(out_data), 0);
        send(1, 500, 1'b0, "R4 right independent");
        chk(out_data == 500, "R4 right est zero", longint'(out_data), 500);
        go_idle(1);
    endtask

    // R5: hold keeps subtracting the held estimate; tracking resumes after release.
    task automatic t_hold();
        do_reset();
        for (int i = 0; i < 2000; i++) send(0, -300, 1'b0, "R2 train left");
        for (int i = 0; i < 50; i++) send(0, 2000, 1'b1, "R5 held estimate");
        chk(out_data == 2300, "R5 held offset removed", longint'(out_data), 2300);
        for (int i = 0; i < 20; i++) send(0, 2000, 1'b0, "R5 resume tracking");
        chk(out_data < 2300, "R5 tracking resumed", longint'(out_data), 2299);
        go_idle(1);
    endtask

    // R7: idle cycles change nothing.
    task automatic t_idle();
        do_reset();
        for (int i = 0; i < 40; i++) send(1, 4000, 1'b0, "R2 train right");
        go_idle(6);
        send(1, 4000, 1'b0, "R7 estimate unchanged across idle");
        go_idle(1);
    endtask

    // R3: clamp at both ends with interleaved channels.
    task automatic t_sat();
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            send(0, MINV, 1'b0, "R2 train left low");
            send(1, MAXV, 1'b0, "R2 train right high");
        end
        send(0, MAXV, 1'b1, "R3 positive clamp");
        chk(out_data == MAXV, "R3 positive clamp value", longint'(out_data), MAXV);
        send(1, MINV, 1'b1, "R3 negative clamp");
        chk(out_data == MINV, "R3 negative clamp value", longint'(out_data), MINV);
        go_idle(1);
        // R8: reset mid-run clears the trained estimate.
        do_reset();
        send(0, 100, 1'b0, "R8 estimate cleared");
        go_idle(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_track();
        t_hold();
        t_idle();
        t_sat();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule